// File: doc/BRIEF.md
# Indexed Host Buffer Bridge

This block lets an external host and the on-chip CPU share one 2-kbyte buffer memory, held as 1024 halfwords in two banks of 512 halfwords. The host sees only a narrow, synchronous 16-bit slave port. It first writes a register number with the select line `h_idx` high. Later cycles with `h_idx` low read or write whichever register that number picks. The buffer window register reaches memory through an internal pointer. The pointer advances by one halfword after every window access, so a block transfer needs one index write and then a run of plain data cycles.

The CPU reaches the same memory directly by halfword address over a simple request port. A second address space on that port holds its doorbell and enable registers. Each side can ring a doorbell toward the other. Each doorbell sets a sticky flag that drives a gated interrupt line. A control bit reverses the two bytes of every halfword moved through the host window. The memory has a single port, and the CPU always wins it. A host window access that meets a CPU memory access is parked, and `h_wait` is raised until the access completes.

Top module: `hostbuf_bridge`

## Requirements
- R1: After a synchronous reset, `h_rvalid`, `cpu_rvalid`, `h_wait`, `h_irq` and `cpu_irq` are low, and the index, pointer and control registers read 0.
- R2: A host cycle (`h_cs` with `h_wr` or `h_rd`) with `h_idx`=1 and `h_wr`=1 loads the index from `h_wdata[2:0]`. Cycles with `h_idx`=0 access the indexed register: 0 window, 1 pointer, 2 control, 3 host flag, 4 CPU doorbell. Reads of indices 5..7 return 0, and writes to them change nothing.
- R3: A read accepted in cycle G returns data with a one-cycle `h_rvalid` (or `cpu_rvalid`) pulse in cycle G+2. The host window read is accepted in the cycle it executes.
- R4: Every window read or write advances the 9-bit pointer by one. A pointer-register write loads `h_wdata[8:0]`, and a pointer read returns it zero-extended.
- R5: Control bit 1 selects the bank and forms memory halfword address bit 9 above the pointer. The pointer wraps from 511 to 0 inside the selected bank.
- R6: When control bit 0 is 1, window writes store `h_wdata[7:0]` in bits 15:8 and `h_wdata[15:8]` in bits 7:0, and window reads swap back the same way. The CPU always sees memory unswapped.
- R7: CPU address `cpu_addr[9:0]` (with `cpu_reg`=0) names the same halfword as host address {bank, pointer}. Data written by either side is read back by the other.
- R8: If a CPU memory access (`cpu_req`, `cpu_reg`=0) falls in the same cycle as a host window cycle, `h_wait` is high from the next cycle. The host access, holding its captured write data, executes in the first later cycle with no CPU memory access.
- R9: A CPU write of 1 in bit 0 to CPU register 2 sets the host flag. The flag reads as bit 0 at host index 3, and a host write of 1 in bit 0 there clears it. `h_irq` is the flag ANDed with control bit 2, registered one cycle later.
- R10: A host write of 1 in bit 0 to index 4 sets the CPU flag. The CPU reads it as bit 0 of CPU register 0 and clears it by writing 1 there. `cpu_irq` is the flag ANDed with bit 0 of CPU register 1, registered one cycle later.
- R11: Doorbell and clear writes with bit 0 equal to 0 leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cs | input | 1 | Host cycle select |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_idx | input | 1 | 1: write loads the index register; 0: access the indexed register |
| h_wdata | input | 16 | Host write data |
| h_rdata | output | 16 | Host read data |
| h_rvalid | output | 1 | Host read data valid pulse |
| h_wait | output | 1 | Host window access parked behind the CPU |
| h_irq | output | 1 | Interrupt toward the host |
| cpu_req | input | 1 | CPU access request |
| cpu_we | input | 1 | CPU write enable |
| cpu_reg | input | 1 | 0: buffer memory, 1: CPU register space |
| cpu_addr | input | 10 | CPU halfword address or register number |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| cpu_rvalid | output | 1 | CPU read data valid pulse |
| cpu_irq | output | 1 | Interrupt toward the CPU |

## Verification
The bench builds the bridge with its default parameters: a 16-bit data path and 9-bit bank offsets. These give full 512-halfword banks, so the 511-to-0 pointer wrap and the bank bit at CPU addresses 512 and 1023 are both reachable. The 16-bit width gives a real two-byte swap in the endian path. A behavioural model runs every cycle and predicts the read pulses, the wait flag and both interrupt lines. This model also covers a clash in which the CPU holds the memory for three cycles in a row.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  localparam int IDX_W = 3;

  // Host register numbers selected through the index register
  typedef enum logic [IDX_W-1:0] {
    IX_DATA  = 3'd0,
    IX_PTR   = 3'd1,
    IX_CTRL  = 3'd2,
    IX_HFLAG = 3'd3,
    IX_RING  = 3'd4
  } hidx_e;

  // CPU register space numbers
  typedef enum logic [1:0] {
    CR_FLAG  = 2'd0,
    CR_IRQEN = 2'd1,
    CR_RING  = 2'd2
  } creg_e;
endpackage

// File: rtl/hbb_spram.sv
module hbb_spram #(
  parameter int DW = 16,
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      q <= mem[addr];
    end
  end
endmodule

// File: rtl/hbb_doorbell.sv
module hbb_doorbell (
  input  logic clk,
  input  logic rst,
  input  logic ring,
  input  logic clr,
  input  logic en,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (ring)     flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      irq <= flag & en;
    end
  end

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    flag && !clr |=> flag);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(flag && en));
endmodule

// File: rtl/hbb_host_port.sv
module hbb_host_port
  import hbb_pkg::*;
#(
  parameter int DW      = 16,
  parameter int BANK_AW = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             h_cs,
  input  logic             h_rd,
  input  logic             h_wr,
  input  logic             h_idx,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_rdata,
  output logic             h_rvalid,
  output logic             h_wait,
  input  logic             cpu_busy,
  input  logic [DW-1:0]    ram_q,
  input  logic             host_flag,
  output logic             ram_req,
  output logic             ram_we,
  output logic [BANK_AW:0] ram_addr,
  output logic [DW-1:0]    ram_wdata,
  output logic             ring_cpu,
  output logic             clr_hflag,
  output logic             hirq_en
);
  localparam int NB = DW / 8;

  logic [IDX_W-1:0]   index_q;
  logic [BANK_AW-1:0] ptr_q;
  logic               swap_q, bank_q, hirq_en_q;
  logic               pend_q, pend_wr_q;
  logic [DW-1:0]      pend_data_q;
  logic               s1_valid, s1_ram, s1_swap;
  logic [DW-1:0]      s1_val;

  logic          strobe, data_cyc, reg_wr, reg_rd, new_ram, go, op_wr;
  logic [DW-1:0] op_data, wr_swapped, rd_swapped, reg_val;

  always_comb begin
    strobe   = h_cs & (h_rd | h_wr);
    data_cyc = strobe & ~h_idx;
    reg_wr   = data_cyc &  h_wr & (index_q != IX_DATA);
    reg_rd   = data_cyc & ~h_wr & (index_q != IX_DATA);
    new_ram  = data_cyc & (index_q == IX_DATA) & ~pend_q;
    go       = (new_ram | pend_q) & ~cpu_busy;
    op_wr    = pend_q ? pend_wr_q   : h_wr;
    op_data  = pend_q ? pend_data_q : h_wdata;
  end

  generate
    for (genvar b = 0; b < NB; b++) begin : g_swap
      assign wr_swapped[b*8 +: 8] = op_data[(NB-1-b)*8 +: 8];
      assign rd_swapped[b*8 +: 8] = ram_q[(NB-1-b)*8 +: 8];
    end
  endgenerate

  always_comb begin
    case (index_q)
      IX_PTR:   reg_val = DW'(ptr_q);
      IX_CTRL:  reg_val = DW'({hirq_en_q, bank_q, swap_q});
      IX_HFLAG: reg_val = DW'(host_flag);
      default:  reg_val = '0;
    endcase
  end

  assign ram_req   = go;
  assign ram_we    = op_wr;
  assign ram_addr  = {bank_q, ptr_q};
  assign ram_wdata = swap_q ? wr_swapped : op_data;
  assign h_wait    = pend_q;
  assign ring_cpu  = reg_wr & (index_q == IX_RING)  & h_wdata[0];
  assign clr_hflag = reg_wr & (index_q == IX_HFLAG) & h_wdata[0];
  assign hirq_en   = hirq_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      index_q     <= '0;
      ptr_q       <= '0;
      swap_q      <= 1'b0;
      bank_q      <= 1'b0;
      hirq_en_q   <= 1'b0;
      pend_q      <= 1'b0;
      pend_wr_q   <= 1'b0;
      pend_data_q <= '0;
      s1_valid    <= 1'b0;
      s1_ram      <= 1'b0;
      s1_swap     <= 1'b0;
      s1_val      <= '0;
      h_rvalid    <= 1'b0;
      h_rdata     <= '0;
    end else begin
      if (strobe && h_idx && h_wr) index_q <= h_wdata[IDX_W-1:0];

      if (go)                               ptr_q <= ptr_q + 1'b1;
      else if (reg_wr && index_q == IX_PTR) ptr_q <= h_wdata[BANK_AW-1:0];

      if (reg_wr && index_q == IX_CTRL) begin
        swap_q    <= h_wdata[0];
        bank_q    <= h_wdata[1];
        hirq_en_q <= h_wdata[2];
      end

      if (go) begin
        pend_q <= 1'b0;
      end else if (new_ram) begin
        pend_q      <= 1'b1;
        pend_wr_q   <= h_wr;
        pend_data_q <= h_wdata;
      end

      s1_valid <= (go & ~op_wr) | reg_rd;
      s1_ram   <= go & ~op_wr;
      s1_swap  <= swap_q;
      s1_val   <= reg_val;

      h_rvalid <= s1_valid;
      if (s1_valid) h_rdata <= s1_ram ? (s1_swap ? rd_swapped : ram_q) : s1_val;
    end
  end

  assert_wait_on_clash_R8: assert property (@(posedge clk) disable iff (rst)
    new_ram && cpu_busy |=> h_wait);

  assert_wait_release_R8: assert property (@(posedge clk) disable iff (rst)
    h_wait && !cpu_busy |=> !h_wait);

  assert_ptr_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    go && (ptr_q == '1) |=> (ptr_q == '0));
endmodule

// File: rtl/hostbuf_bridge.sv
module hostbuf_bridge
  import hbb_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int BANK_AW = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 h_cs,
  input  logic                 h_rd,
  input  logic                 h_wr,
  input  logic                 h_idx,
  input  logic [DATA_W-1:0]    h_wdata,
  output logic [DATA_W-1:0]    h_rdata,
  output logic                 h_rvalid,
  output logic                 h_wait,
  output logic                 h_irq,
  input  logic                 cpu_req,
  input  logic                 cpu_we,
  input  logic                 cpu_reg,
  input  logic [BANK_AW:0]     cpu_addr,
  input  logic [DATA_W-1:0]    cpu_wdata,
  output logic [DATA_W-1:0]    cpu_rdata,
  output logic                 cpu_rvalid,
  output logic                 cpu_irq
);
  localparam int ADDR_W = BANK_AW + 1;

  logic              cpu_ram;
  logic              hp_req, hp_we, hp_ring_cpu, hp_clr_hflag, hp_hirq_en;
  logic [ADDR_W-1:0] hp_addr;
  logic [DATA_W-1:0] hp_wdata;
  logic              ram_en, ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [DATA_W-1:0] ram_wdata, ram_q;
  logic              host_flag, cpu_flag;
  logic              cirq_en_q, cpu_clr, cpu_ring_host;
  logic              c1_valid, c1_ram;
  logic [DATA_W-1:0] c1_val, creg_val;

  assign cpu_ram = cpu_req & ~cpu_reg;

  // CPU has fixed priority on the single memory port
  always_comb begin
    ram_en    = cpu_ram | hp_req;
    ram_we    = cpu_ram ? cpu_we    : hp_we;
    ram_addr  = cpu_ram ? cpu_addr  : hp_addr;
    ram_wdata = cpu_ram ? cpu_wdata : hp_wdata;
  end

  hbb_spram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .q(ram_q)
  );

  hbb_host_port #(.DW(DATA_W), .BANK_AW(BANK_AW)) u_host (
    .clk(clk), .rst(rst),
    .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_idx(h_idx), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_wait(h_wait),
    .cpu_busy(cpu_ram), .ram_q(ram_q), .host_flag(host_flag),
    .ram_req(hp_req), .ram_we(hp_we), .ram_addr(hp_addr), .ram_wdata(hp_wdata),
    .ring_cpu(hp_ring_cpu), .clr_hflag(hp_clr_hflag), .hirq_en(hp_hirq_en)
  );

  // CPU register space
  always_comb begin
    cpu_clr       = cpu_req & cpu_reg & cpu_we & (cpu_addr[1:0] == CR_FLAG) & cpu_wdata[0];
    cpu_ring_host = cpu_req & cpu_reg & cpu_we & (cpu_addr[1:0] == CR_RING) & cpu_wdata[0];
    case (cpu_addr[1:0])
      CR_FLAG:  creg_val = DATA_W'(cpu_flag);
      CR_IRQEN: creg_val = DATA_W'(cirq_en_q);
      default:  creg_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cirq_en_q  <= 1'b0;
      c1_valid   <= 1'b0;
      c1_ram     <= 1'b0;
      c1_val     <= '0;
      cpu_rvalid <= 1'b0;
      cpu_rdata  <= '0;
    end else begin
      if (cpu_req && cpu_reg && cpu_we && cpu_addr[1:0] == CR_IRQEN)
        cirq_en_q <= cpu_wdata[0];
      c1_valid   <= cpu_req & ~cpu_we;
      c1_ram     <= cpu_ram;
      c1_val     <= creg_val;
      cpu_rvalid <= c1_valid;
      if (c1_valid) cpu_rdata <= c1_ram ? ram_q : c1_val;
    end
  end

  hbb_doorbell u_to_host (
    .clk(clk), .rst(rst), .ring(cpu_ring_host), .clr(hp_clr_hflag),
    .en(hp_hirq_en), .flag(host_flag), .irq(h_irq)
  );

  hbb_doorbell u_to_cpu (
    .clk(clk), .rst(rst), .ring(hp_ring_cpu), .clr(cpu_clr),
    .en(cirq_en_q), .flag(cpu_flag), .irq(cpu_irq)
  );

  assert_one_owner_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_ram |-> !hp_req);

  assert_cpu_latency_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_we |-> ##2 cpu_rvalid);
endmodule

// File: tb/sim_hostbuf_bridge.sv
module sim_hostbuf_bridge;
  localparam int CLK_P = 10;
  localparam int DW    = 16;
  localparam int BAW   = 9;

  logic          clk = 1'b0, rst = 1'b1;
  logic          h_cs = 0, h_rd = 0, h_wr = 0, h_idx = 0;
  logic [DW-1:0] h_wdata = '0, h_rdata;
  logic          h_rvalid, h_wait, h_irq;
  logic          cpu_req = 0, cpu_we = 0, cpu_reg = 0;
  logic [BAW:0]  cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic          cpu_rvalid, cpu_irq;

  hostbuf_bridge #(.DATA_W(DW), .BANK_AW(BAW)) u0 (
    .clk(clk), .rst(rst),
    .h_cs(h_cs), .h_rd(h_rd), .h_wr(h_wr), .h_idx(h_idx), .h_wdata(h_wdata),
    .h_rdata(h_rdata), .h_rvalid(h_rvalid), .h_wait(h_wait), .h_irq(h_irq),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_reg(cpu_reg), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_rvalid(cpu_rvalid),
    .cpu_irq(cpu_irq)
  );

  always #(CLK_P/2) clk = ~clk;

  int    vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit    done = 0;

  // ---------------- behavioural reference model ----------------
  int            m_cyc = 0;
  int            m_idx, m_ptr, m_bank, m_swap, m_hen, m_cen;
  bit            m_hflag, m_cflag, m_hirq, m_cirq, m_pend, m_pwr;
  logic [DW-1:0] m_pdata;
  logic [DW-1:0] mem [1024];
  int            hq_due[$], cq_due[$];
  logic [DW-1:0] hq_val[$], cq_val[$];

  function automatic logic [DW-1:0] sw(input logic [DW-1:0] x);
    return {x[7:0], x[15:8]};
  endfunction

  always @(posedge clk) begin
    int c, a, haddr, ewr, exec;
    bit cram, hstb, p0, hset, hclr, cset, cclr, nh, nc;
    logic [DW-1:0] ed, rv;
    c = m_cyc;
    if (rst) begin
      m_idx = 0; m_ptr = 0; m_bank = 0; m_swap = 0; m_hen = 0; m_cen = 0;
      m_hflag = 0; m_cflag = 0; m_hirq = 0; m_cirq = 0; m_pend = 0;
      hq_due.delete(); hq_val.delete(); cq_due.delete(); cq_val.delete();
    end else begin
      cram = cpu_req && !cpu_reg;
      nh = m_hflag && (m_hen != 0);
      nc = m_cflag && (m_cen != 0);
      hset = 0; hclr = 0; cset = 0; cclr = 0;
      if (cpu_req) begin
        if (!cpu_reg) begin
          if (cpu_we) mem[cpu_addr] = cpu_wdata;
          else begin cq_due.push_back(c + 2); cq_val.push_back(mem[cpu_addr]); end
        end else begin
          a = cpu_addr % 4;
          if (cpu_we) begin
            if (a == 0 && cpu_wdata[0]) cclr = 1;
            if (a == 1) m_cen = cpu_wdata[0];
            if (a == 2 && cpu_wdata[0]) hset = 1;
          end else begin
            rv = (a == 0) ? DW'(m_cflag) : (a == 1) ? DW'(m_cen) : '0;
            cq_due.push_back(c + 2); cq_val.push_back(rv);
          end
        end
      end
      hstb = h_cs && (h_rd || h_wr);
      p0 = m_pend; exec = 0; ewr = 0; ed = '0;
      if (p0 && !cram) begin exec = 1; ewr = m_pwr; ed = m_pdata; m_pend = 0; end
      if (hstb && h_idx && h_wr) m_idx = h_wdata[2:0];
      if (hstb && !h_idx) begin
        if (m_idx == 0) begin
          if (!p0) begin
            if (cram) begin m_pend = 1; m_pwr = h_wr; m_pdata = h_wdata; end
            else begin exec = 1; ewr = h_wr; ed = h_wdata; end
          end
        end else if (h_wr) begin
          case (m_idx)
            1: m_ptr = h_wdata[8:0];
            2: begin m_swap = h_wdata[0]; m_bank = h_wdata[1]; m_hen = h_wdata[2]; end
            3: if (h_wdata[0]) hclr = 1;
            4: if (h_wdata[0]) cset = 1;
            default: ;
          endcase
        end else begin
          case (m_idx)
            1: rv = DW'(m_ptr);
            2: rv = DW'(m_hen * 4 + m_bank * 2 + m_swap);
            3: rv = DW'(m_hflag);
            default: rv = '0;
          endcase
          hq_due.push_back(c + 2); hq_val.push_back(rv);
        end
      end
      if (exec != 0) begin
        haddr = m_bank * 512 + m_ptr;
        if (ewr != 0) mem[haddr] = (m_swap != 0) ? sw(ed) : ed;
        else begin
          hq_due.push_back(c + 2);
          hq_val.push_back((m_swap != 0) ? sw(mem[haddr]) : mem[haddr]);
        end
        m_ptr = (m_ptr + 1) % 512;
      end
      if (hset) m_hflag = 1; else if (hclr) m_hflag = 0;
      if (cset) m_cflag = 1; else if (cclr) m_cflag = 0;
      m_hirq = nh; m_cirq = nc;
    end
    m_cyc = c + 1;
  end

  // ---------------- per-cycle comparison ----------------
  task automatic cmp(input string what, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h (cycle %0d)", cur_req, what, got, exp, m_cyc);
    end
  endtask

  always @(negedge clk) begin
    bit ehv, ecv;
    logic [DW-1:0] ehd, ecd;
    if (!rst && !done) begin
      while (hq_due.size() > 0 && hq_due[0] < m_cyc) begin
        void'(hq_due.pop_front()); void'(hq_val.pop_front());
        cmp("R3 missed host read", 1'b0, 1'b1);
      end
      while (cq_due.size() > 0 && cq_due[0] < m_cyc) begin
        void'(cq_due.pop_front()); void'(cq_val.pop_front());
        cmp("R3 missed cpu read", 1'b0, 1'b1);
      end
      ehv = hq_due.size() > 0 && hq_due[0] == m_cyc;
      ecv = cq_due.size() > 0 && cq_due[0] == m_cyc;
      cmp("h_rvalid", DW'(h_rvalid), DW'(ehv));
      cmp("cpu_rvalid", DW'(cpu_rvalid), DW'(ecv));
      if (ehv) begin void'(hq_due.pop_front()); ehd = hq_val.pop_front(); cmp("h_rdata", h_rdata, ehd); end
      if (ecv) begin void'(cq_due.pop_front()); ecd = cq_val.pop_front(); cmp("cpu_rdata", cpu_rdata, ecd); end
      cmp("h_wait", DW'(h_wait), DW'(m_pend));
      cmp("h_irq", DW'(h_irq), DW'(m_hirq));
      cmp("cpu_irq", DW'(cpu_irq), DW'(m_cirq));
    end
  end

  // ---------------- directed stimulus ----------------
  logic [DW-1:0] last_h, last_c;
  always @(negedge clk) begin
    if (h_rvalid)   last_h = h_rdata;
    if (cpu_rvalid) last_c = cpu_rdata;
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic host_op(input bit idx, input bit wr, input logic [DW-1:0] d);
    @(negedge clk);
    h_cs = 1; h_idx = idx; h_wr = wr; h_rd = !wr; h_wdata = d;
    @(negedge clk);
    h_cs = 0; h_wr = 0; h_rd = 0;
    while (h_wait) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic host_reg_wr(input int idx, input logic [DW-1:0] d);
    host_op(1, 1, DW'(idx));
    host_op(0, 1, d);
  endtask

  task automatic host_reg_rd(input int idx);
    host_op(1, 1, DW'(idx));
    host_op(0, 0, '0);
  endtask

  task automatic cpu_op(input bit rg, input bit wr, input int addr, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_req = 1; cpu_reg = rg; cpu_we = wr; cpu_addr = addr[BAW:0]; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk("R1 h_rvalid after reset", DW'(h_rvalid), '0);
    chk("R1 h_wait after reset", DW'(h_wait), '0);
    chk("R1 irqs after reset", DW'({h_irq, cpu_irq}), '0);
    host_op(0, 0, '0);                       // index 0 after reset: window read, result unused
    host_reg_rd(1); chk("R1 pointer after reset (1 from window read)", last_h, 16'd1);
    host_reg_rd(2); chk("R1 control after reset", last_h, 16'd0);

    cur_req = "R4";
    host_reg_wr(1, 16'd5);
    host_reg_rd(1); chk("R4 pointer load", last_h, 16'd5);
    host_op(1, 1, 16'd0);
    host_op(0, 1, 16'h1111); host_op(0, 1, 16'h2222); host_op(0, 1, 16'h3333);
    host_reg_rd(1); chk("R4 pointer after three window writes", last_h, 16'd8);

    cur_req = "R7";
    cpu_op(0, 0, 6, '0); chk("R7 cpu sees host write", last_c, 16'h2222);
    cpu_op(0, 1, 20, 16'h1234);
    host_reg_wr(1, 16'd20); host_op(1, 1, 16'd0); host_op(0, 0, '0);
    chk("R7 host sees cpu write", last_h, 16'h1234);

    cur_req = "R6";
    host_reg_wr(2, 16'd1);
    host_reg_wr(1, 16'd30); host_op(1, 1, 16'd0); host_op(0, 1, 16'hABCD);
    cpu_op(0, 0, 30, '0); chk("R6 swapped store", last_c, 16'hCDAB);
    host_reg_wr(1, 16'd30); host_op(1, 1, 16'd0); host_op(0, 0, '0);
    chk("R6 swapped read back", last_h, 16'hABCD);
    host_reg_wr(1, 16'd20); host_op(1, 1, 16'd0); host_op(0, 0, '0);
    chk("R6 cpu word swapped to host", last_h, 16'h3412);

    cur_req = "R5";
    host_reg_wr(2, 16'd2);
    host_reg_wr(1, 16'd511); host_op(1, 1, 16'd0);
    host_op(0, 1, 16'h5A5A); host_op(0, 1, 16'hA5A5);
    cpu_op(0, 0, 1023, '0); chk("R5 bank 1 top halfword", last_c, 16'h5A5A);
    cpu_op(0, 0, 512, '0);  chk("R5 wrap stays in bank 1", last_c, 16'hA5A5);
    host_reg_rd(1); chk("R5 pointer wrapped", last_h, 16'd1);

    cur_req = "R8";
    host_reg_wr(2, 16'd0);
    host_reg_wr(1, 16'd40); host_op(1, 1, 16'd0);
    @(negedge clk);
    cpu_req = 1; cpu_reg = 0; cpu_we = 0; cpu_addr = 10'd6;
    h_cs = 1; h_idx = 0; h_wr = 1; h_rd = 0; h_wdata = 16'h7777;
    @(negedge clk);
    h_cs = 0; h_wr = 0; h_wdata = 16'h0000;
    chk("R8 wait raised after clash", DW'(h_wait), 16'd1);
    @(negedge clk);
    @(negedge clk);
    chk("R8 wait held while cpu owns memory", DW'(h_wait), 16'd1);
    cpu_req = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 wait released", DW'(h_wait), 16'd0);
    repeat (2) @(negedge clk);
    cpu_op(0, 0, 40, '0); chk("R8 parked write landed", last_c, 16'h7777);
    host_reg_rd(1); chk("R8 pointer advanced once", last_h, 16'd41);

    cur_req = "R10";
    cpu_op(1, 1, 1, 16'd1);
    host_reg_wr(4, 16'd0);
    cpu_op(1, 0, 0, '0); chk("R11 zero doorbell ignored", last_c, 16'd0);
    host_reg_wr(4, 16'd1);
    cpu_op(1, 0, 0, '0); chk("R10 cpu flag set", last_c, 16'd1);
    chk("R10 cpu_irq high", DW'(cpu_irq), 16'd1);
    cpu_op(1, 1, 0, 16'd0);
    cpu_op(1, 0, 0, '0); chk("R11 zero clear ignored", last_c, 16'd1);
    cpu_op(1, 1, 0, 16'd1);
    cpu_op(1, 0, 0, '0); chk("R10 cpu flag cleared", last_c, 16'd0);
    chk("R10 cpu_irq low", DW'(cpu_irq), 16'd0);

    cur_req = "R9";
    host_reg_wr(2, 16'd4);
    cpu_op(1, 1, 2, 16'd1);
    host_reg_rd(3); chk("R9 host flag set", last_h, 16'd1);
    chk("R9 h_irq high", DW'(h_irq), 16'd1);
    host_reg_wr(3, 16'd1);
    host_reg_rd(3); chk("R9 host flag cleared", last_h, 16'd0);
    chk("R9 h_irq low", DW'(h_irq), 16'd0);
    host_reg_wr(2, 16'd0);
    cpu_op(1, 1, 2, 16'd1);
    chk("R9 h_irq masked by enable", DW'(h_irq), 16'd0);
    host_reg_wr(3, 16'd1);

    cur_req = "R2";
    host_reg_rd(6); chk("R2 unused index reads zero", last_h, 16'd0);
    host_reg_wr(5, 16'hFFFF);
    host_reg_rd(2); chk("R2 unused index write ignored", last_h, 16'd0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      done = 1;
      miscompares++;
      $display("FAIL watchdog expired during %s", cur_req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule